// File: doc/BRIEF.md
# Tile Elementwise Integer Add Engine

This block adds two source tiles lane by lane and writes the sums into a destination tile. All three tiles sit in a tile register file that lies outside the block. Each tile is described by four values: a base element address, a row pitch in elements, a count of valid rows and a count of valid columns. It also carries an element type code. Tiles are row-major, so element (i, j) of a tile lives at `base + i*pitch + j`. On an accepted start pulse the engine latches the three descriptors. It walks the destination's valid region row by row, issues one source read pair per cycle, and writes each wrapped sum one cycle after its reads.

The destination's valid region alone defines the work. A source lane whose coordinate falls outside that source's own valid region is not read, and the engine uses an all-ones value of the element width in its place. Work is accounted in repeats of eight elements. Completion follows a fixed schedule that depends only on the repeat count, so software can rely on a known latency.

Top module: `tadd_engine`

## Requirements
- R1: For an accepted start, exactly the addresses `dst_base + i*dst_pitch + j` with i < dst_rows and j < dst_cols are written, each once. Every other location of the register file keeps its previous contents.
- R2: The value written at destination (i, j) is the sum of the left and right source values at their own (i, j) addresses. The sum is taken modulo the element width, with no saturation. Type code 0 selects 8-bit elements, code 1 selects 16-bit elements and code 2 selects 32-bit elements. Source bits above the element width are ignored, and written bits above the element width are zero.
- R3: When (i, j) lies outside a source's own valid region (i >= rows or j >= cols of that source), that source contributes all ones of the element width (0xFF, 0xFFFF or 0xFFFFFFFF) and its read enable stays low for that element.
- R4: When the three type codes differ, or when any of them equals the unused code 3, the start is rejected. `err` is high for the cycle after the start edge, `busy` stays low, and no read or write is issued.
- R5: With N = dst_rows*dst_cols and R = ceil(N/8), `done` rises after edge 14 + 17 + 2R + 18(R-1), counting the start edge as edge 0. For N = 0 it rises after edge 31, and nothing is written.
- R6: `busy` is high from the edge that accepts a start up to and including the single-cycle `done` pulse, then falls. A start, or a change of the descriptor inputs, while `busy` is high has no effect on the running operation. After reset, `busy`, `done`, `err`, `wr_en` and both read enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled when idle |
| dst_base | input | ADDR_W | Destination base element address |
| dst_rows | input | DIM_W | Destination valid rows |
| dst_cols | input | DIM_W | Destination valid columns |
| dst_pitch | input | ADDR_W | Destination row pitch in elements |
| dst_type | input | 2 | Destination element type code |
| lhs_base | input | ADDR_W | Left source base address |
| lhs_rows | input | DIM_W | Left source valid rows |
| lhs_cols | input | DIM_W | Left source valid columns |
| lhs_pitch | input | ADDR_W | Left source row pitch |
| lhs_type | input | 2 | Left source element type code |
| rhs_base | input | ADDR_W | Right source base address |
| rhs_rows | input | DIM_W | Right source valid rows |
| rhs_cols | input | DIM_W | Right source valid columns |
| rhs_pitch | input | ADDR_W | Right source row pitch |
| rhs_type | input | 2 | Right source element type code |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Single-cycle completion pulse |
| err | output | 1 | Start rejected for a type fault |
| rd0_en | output | 1 | Left source read enable |
| rd0_addr | output | ADDR_W | Left source read address |
| rd0_data | input | 32 | Left source data, valid in the cycle its address is presented |
| rd1_en | output | 1 | Right source read enable |
| rd1_addr | output | ADDR_W | Right source read address |
| rd1_data | input | 32 | Right source data, valid in the cycle its address is presented |
| wr_en | output | 1 | Destination write enable |
| wr_addr | output | ADDR_W | Destination write address |
| wr_data | output | 32 | Destination write data |

## Verification
The bench builds the engine with its default parameters: a 12-bit address, 8-bit dimensions, eight-element repeats and the 14/17/2/18 schedule. The 4096-word space holds three 16x64 tiles, so the full-size case with 128 repeats and a 2573-cycle completion can be run. The 8-bit dimensions also allow small ragged regions. Those regions cover partial last repeats, sources clipped by rows or by columns, an empty source region and an empty destination region.

// File: rtl/tadd_pkg.sv
package tadd_pkg;

   localparam int ELEM_BITS = 32;

   typedef enum logic [1:0] {
      ET_B8   = 2'd0,
      ET_B16  = 2'd1,
      ET_B32  = 2'd2,
      ET_NONE = 2'd3
   } elem_t;

   function automatic logic [ELEM_BITS-1:0] elem_mask(input elem_t et);
      case (et)
         ET_B8:   elem_mask = 32'h0000_00FF;
         ET_B16:  elem_mask = 32'h0000_FFFF;
         default: elem_mask = 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/tadd_addr_gen.sv
module tadd_addr_gen #(
   parameter int ADDR_W = 12,
   parameter int DIM_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] pitch_i,
   input  logic [DIM_W-1:0]  rows_i,
   input  logic [DIM_W-1:0]  cols_i,
   input  logic              row_adv,
   input  logic [DIM_W-1:0]  row_idx,
   input  logic [DIM_W-1:0]  col_idx,
   output logic [ADDR_W-1:0] addr_o,
   output logic              inside_o
);

   localparam int PAD_W = ADDR_W - DIM_W;

   logic [ADDR_W-1:0] row_base_q;
   logic [ADDR_W-1:0] pitch_q;
   logic [DIM_W-1:0]  rows_q;
   logic [DIM_W-1:0]  cols_q;

   // Row start advances by the pitch; no per-element multiply.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_base_q <= '0;
         pitch_q    <= '0;
         rows_q     <= '0;
         cols_q     <= '0;
      end else if (load) begin
         row_base_q <= base_i;
         pitch_q    <= pitch_i;
         rows_q     <= rows_i;
         cols_q     <= cols_i;
      end else if (row_adv) begin
         row_base_q <= row_base_q + pitch_q;
      end
   end

   assign addr_o   = row_base_q + {{PAD_W{1'b0}}, col_idx};
   assign inside_o = (row_idx < rows_q) && (col_idx < cols_q);

endmodule

// File: rtl/tadd_lane_alu.sv
module tadd_lane_alu
   import tadd_pkg::*;
(
   input  elem_t                 etype,
   input  logic                  a_en,
   input  logic [ELEM_BITS-1:0]  a_data,
   input  logic                  b_en,
   input  logic [ELEM_BITS-1:0]  b_data,
   output logic [ELEM_BITS-1:0]  sum_o
);

   logic [ELEM_BITS-1:0] mask;
   logic [ELEM_BITS-1:0] a_op;
   logic [ELEM_BITS-1:0] b_op;

   always_comb begin
      mask  = elem_mask(etype);
      a_op  = a_en ? (a_data & mask) : mask;
      b_op  = b_en ? (b_data & mask) : mask;
      sum_o = (a_op + b_op) & mask;
   end

endmodule

// File: rtl/tadd_engine.sv
module tadd_engine
   import tadd_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int DIM_W    = 8,
   parameter int LANES    = 8,
   parameter int STARTUP  = 14,
   parameter int COMPL    = 17,
   parameter int RPT      = 2,
   parameter int INTERVAL = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] dst_base,
   input  logic [DIM_W-1:0]  dst_rows,
   input  logic [DIM_W-1:0]  dst_cols,
   input  logic [ADDR_W-1:0] dst_pitch,
   input  logic [1:0]        dst_type,
   input  logic [ADDR_W-1:0] lhs_base,
   input  logic [DIM_W-1:0]  lhs_rows,
   input  logic [DIM_W-1:0]  lhs_cols,
   input  logic [ADDR_W-1:0] lhs_pitch,
   input  logic [1:0]        lhs_type,
   input  logic [ADDR_W-1:0] rhs_base,
   input  logic [DIM_W-1:0]  rhs_rows,
   input  logic [DIM_W-1:0]  rhs_cols,
   input  logic [ADDR_W-1:0] rhs_pitch,
   input  logic [1:0]        rhs_type,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              rd0_en,
   output logic [ADDR_W-1:0] rd0_addr,
   input  logic [31:0]       rd0_data,
   output logic              rd1_en,
   output logic [ADDR_W-1:0] rd1_addr,
   input  logic [31:0]       rd1_data,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [31:0]       wr_data
);

   localparam int NTILE  = 3;            // 0 destination, 1 left, 2 right
   localparam int LG_LN  = $clog2(LANES);
   localparam int PROD_W = 2 * DIM_W;
   localparam int CNT_W  = PROD_W + 6;

   generate
      if (LANES < 1 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("LANES must be a power of two");
      end
      if (ADDR_W <= DIM_W) begin : g_bad_addr
         $error("ADDR_W must exceed DIM_W");
      end
      if (STARTUP + COMPL < 1) begin : g_bad_sched
         $error("schedule must be at least one cycle");
      end
   endgenerate

   // ---------------- descriptor intake ----------------
   logic [ADDR_W-1:0] base_in  [NTILE];
   logic [ADDR_W-1:0] pitch_in [NTILE];
   logic [DIM_W-1:0]  rows_in  [NTILE];
   logic [DIM_W-1:0]  cols_in  [NTILE];

   assign base_in[0]  = dst_base;   assign base_in[1]  = lhs_base;   assign base_in[2]  = rhs_base;
   assign pitch_in[0] = dst_pitch;  assign pitch_in[1] = lhs_pitch;  assign pitch_in[2] = rhs_pitch;
   assign rows_in[0]  = dst_rows;   assign rows_in[1]  = lhs_rows;   assign rows_in[2]  = rhs_rows;
   assign cols_in[0]  = dst_cols;   assign cols_in[1]  = lhs_cols;   assign cols_in[2]  = rhs_cols;

   logic types_ok, accept, reject;
   assign types_ok = (dst_type == lhs_type) && (dst_type == rhs_type)
                     && (elem_t'(dst_type) != ET_NONE);
   assign accept   = start && !busy && types_ok;
   assign reject   = start && !busy && !types_ok;

   logic [DIM_W-1:0] rows_q, cols_q;
   elem_t            etype_q;

   // ---------------- region walk ----------------
   logic             walking;
   logic [DIM_W-1:0] ri, cj;
   logic             last_col, last_row, row_adv;

   assign last_col = (cj == cols_q - 1'b1);
   assign last_row = (ri == rows_q - 1'b1);
   assign row_adv  = walking && last_col;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         walking <= 1'b0;
         ri      <= '0;
         cj      <= '0;
         rows_q  <= '0;
         cols_q  <= '0;
         etype_q <= ET_B8;
      end else if (accept) begin
         walking <= (dst_rows != '0) && (dst_cols != '0);
         ri      <= '0;
         cj      <= '0;
         rows_q  <= dst_rows;
         cols_q  <= dst_cols;
         etype_q <= elem_t'(dst_type);
      end else if (walking) begin
         if (last_col) begin
            cj <= '0;
            ri <= ri + 1'b1;
            if (last_row) walking <= 1'b0;
         end else begin
            cj <= cj + 1'b1;
         end
      end
   end

   // ---------------- per-tile address generators ----------------
   logic [ADDR_W-1:0] addr_t   [NTILE];
   logic              inside_t [NTILE];

   generate
      for (genvar t = 0; t < NTILE; t++) begin : g_tile
         tadd_addr_gen #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_ag (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (accept),
            .base_i   (base_in[t]),
            .pitch_i  (pitch_in[t]),
            .rows_i   (rows_in[t]),
            .cols_i   (cols_in[t]),
            .row_adv  (row_adv),
            .row_idx  (ri),
            .col_idx  (cj),
            .addr_o   (addr_t[t]),
            .inside_o (inside_t[t])
         );
      end
   endgenerate

   // ---------------- issue and write stages ----------------
   logic              iss_v;
   logic [ADDR_W-1:0] iss_dst;
   logic [31:0]       sum;

   tadd_lane_alu u_alu (
      .etype  (etype_q),
      .a_en   (rd0_en),
      .a_data (rd0_data),
      .b_en   (rd1_en),
      .b_data (rd1_data),
      .sum_o  (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iss_v    <= 1'b0;
         iss_dst  <= '0;
         rd0_en   <= 1'b0;
         rd0_addr <= '0;
         rd1_en   <= 1'b0;
         rd1_addr <= '0;
         wr_en    <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         iss_v    <= walking;
         iss_dst  <= addr_t[0];
         rd0_en   <= walking && inside_t[1];
         rd0_addr <= addr_t[1];
         rd1_en   <= walking && inside_t[2];
         rd1_addr <= addr_t[2];
         wr_en    <= iss_v;
         wr_addr  <= iss_dst;
         wr_data  <= sum;
      end
   end

   // ---------------- completion schedule ----------------
   logic [PROD_W-1:0] n_elem;
   logic [CNT_W-1:0]  reps, lat, cyc_q;

   always_comb begin
      n_elem = rows_q * cols_q;
      reps   = (CNT_W'(n_elem) + CNT_W'(LANES - 1)) >> LG_LN;
      if (reps == '0)
         lat = CNT_W'(STARTUP + COMPL);
      else
         lat = CNT_W'(STARTUP + COMPL) + CNT_W'(RPT) * reps
               + CNT_W'(INTERVAL) * (reps - 1'b1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         err   <= 1'b0;
         cyc_q <= '0;
      end else begin
         err <= reject;
         if (accept) begin
            busy  <= 1'b1;
            done  <= 1'b0;
            cyc_q <= '0;
         end else if (busy) begin
            if (done) begin
               busy <= 1'b0;
               done <= 1'b0;
            end else begin
               cyc_q <= cyc_q + 1'b1;
               done  <= (cyc_q + 1'b1 == lat);
            end
         end
      end
   end

endmodule

// File: rtl/tadd_engine_chk.sv
module tadd_engine_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic err,
   input logic rd0_en,
   input logic rd1_en,
   input logic wr_en
);

   assert_done_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   assert_busy_from_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done && start) |=> busy);

   assert_reject_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!busy && !wr_en && !rd0_en && !rd1_en));

   assert_write_in_run_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy);

   assert_read_in_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd0_en || rd1_en) |-> busy);

endmodule

bind tadd_engine tadd_engine_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .busy   (busy),
   .done   (done),
   .err    (err),
   .rd0_en (rd0_en),
   .rd1_en (rd1_en),
   .wr_en  (wr_en)
);

// File: tb/tadd_engine_test.sv
module tadd_engine_test;

   localparam int ADDR_W = 12;
   localparam int DIM_W  = 8;
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int NCASE  = 6;

   // dbase drows dcols dpitch | lbase lrows lcols lpitch | rbase rrows rcols rpitch | type latency
   localparam int VEC [NCASE][14] = '{
      '{   0,  4,  8, 10,   100,  4,  8,  8,   200,  4,  8,  9, 2,   93},
      '{ 300,  3,  5,  6,   400,  2,  5,  5,   500,  3,  3,  7, 0,   53},
      '{ 600,  5,  3,  4,   700,  5,  3,  3,   800,  5,  4,  5, 1,   53},
      '{ 900,  1,  1,  1,   950,  0,  0,  1,   960,  1,  1,  1, 2,   33},
      '{1024, 16, 64, 64,  2048, 16, 64, 64,  3072, 16, 64, 64, 2, 2573},
      '{  10,  0,  4,  4,    20,  2,  2,  2,    30,  2,  2,  2, 1,   31}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [ADDR_W-1:0] dst_base = '0, dst_pitch = '0, lhs_base = '0, lhs_pitch = '0, rhs_base = '0, rhs_pitch = '0;
   logic [DIM_W-1:0]  dst_rows = '0, dst_cols = '0, lhs_rows = '0, lhs_cols = '0, rhs_rows = '0, rhs_cols = '0;
   logic [1:0]        dst_type = '0, lhs_type = '0, rhs_type = '0;
   logic busy, done, err, rd0_en, rd1_en, wr_en;
   logic [ADDR_W-1:0] rd0_addr, rd1_addr, wr_addr;
   logic [31:0] rd0_data, rd1_data, wr_data;

   logic [31:0] trf  [DEPTH];
   logic [31:0] snap [DEPTH];
   logic [31:0] expm [DEPTH];
   int   wcount = 0;
   logic init_req = 1'b0;
   int   init_seed = 0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   tadd_engine uut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .dst_base(dst_base), .dst_rows(dst_rows), .dst_cols(dst_cols), .dst_pitch(dst_pitch), .dst_type(dst_type),
      .lhs_base(lhs_base), .lhs_rows(lhs_rows), .lhs_cols(lhs_cols), .lhs_pitch(lhs_pitch), .lhs_type(lhs_type),
      .rhs_base(rhs_base), .rhs_rows(rhs_rows), .rhs_cols(rhs_cols), .rhs_pitch(rhs_pitch), .rhs_type(rhs_type),
      .busy(busy), .done(done), .err(err),
      .rd0_en(rd0_en), .rd0_addr(rd0_addr), .rd0_data(rd0_data),
      .rd1_en(rd1_en), .rd1_addr(rd1_addr), .rd1_data(rd1_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   function automatic logic [31:0] pat(input int a, input int s);
      return (32'(a) * 32'h9E37_79B1) ^ (32'(s + 1) * 32'h85EB_CA6B);
   endfunction

   // register file model: combinational reads, clocked writes
   assign rd0_data = trf[rd0_addr];
   assign rd1_data = trf[rd1_addr];

   always @(posedge clk) begin
      if (init_req) begin
         for (int a = 0; a < DEPTH; a++) trf[a] <= pat(a, init_seed);
      end else if (wr_en) begin
         trf[wr_addr] <= wr_data;
         wcount <= wcount + 1;
      end
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic fill(input int seed);
      @(negedge clk);
      init_seed = seed;
      init_req  = 1'b1;
      @(negedge clk);
      init_req  = 1'b0;
      for (int a = 0; a < DEPTH; a++) snap[a] = trf[a];
   endtask

   task automatic drive(input int v[14]);
      dst_base = ADDR_W'(v[0]);  dst_rows = DIM_W'(v[1]);  dst_cols = DIM_W'(v[2]);  dst_pitch = ADDR_W'(v[3]);
      lhs_base = ADDR_W'(v[4]);  lhs_rows = DIM_W'(v[5]);  lhs_cols = DIM_W'(v[6]);  lhs_pitch = ADDR_W'(v[7]);
      rhs_base = ADDR_W'(v[8]);  rhs_rows = DIM_W'(v[9]);  rhs_cols = DIM_W'(v[10]); rhs_pitch = ADDR_W'(v[11]);
      dst_type = 2'(v[12]); lhs_type = 2'(v[12]); rhs_type = 2'(v[12]);
   endtask

   task automatic run_case(input int v[14], input int seed, input bit poke);
      int k;
      int w0;
      logic [31:0] mask, a, b;
      fill(seed);
      w0 = wcount;
      drive(v);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      k = 0;
      while (!done && k < 200000) begin
         @(posedge clk);
         k++;
         @(negedge clk);
         if (poke && k == 10) begin
            start = 1'b1;              // R6: must be ignored while busy
            dst_rows = 1;
            dst_base = 0;
         end else begin
            start = 1'b0;
         end
      end
      check(k == v[13], "R5 completion cycle", k, v[13]);
      check(busy == 1'b1, "R6 busy during done", busy, 1);
      @(posedge clk);
      @(negedge clk);
      check(busy == 1'b0 && done == 1'b0, "R6 idle after done", {busy, done}, 0);
      check(wcount - w0 == v[1] * v[2], "R1 write count", wcount - w0, v[1] * v[2]);
      // expected register file
      mask = (v[12] == 0) ? 32'hFF : (v[12] == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
      for (int x = 0; x < DEPTH; x++) expm[x] = snap[x];
      for (int i = 0; i < v[1]; i++) begin
         for (int j = 0; j < v[2]; j++) begin
            a = (i < v[5] && j < v[6]) ? (snap[v[4] + i * v[7] + j] & mask) : mask;   // R3 fill
            b = (i < v[9] && j < v[10]) ? (snap[v[8] + i * v[11] + j] & mask) : mask;
            expm[v[0] + i * v[3] + j] = (a + b) & mask;                             // R2 wrap
         end
      end
      for (int x = 0; x < DEPTH; x++)
         check(trf[x] === expm[x], (expm[x] !== snap[x]) ? "R2 R3 sum" : "R1 untouched",
               trf[x], expm[x]);
   endtask

   task automatic reject_case(input int v[14], input logic [1:0] lt, input logic [1:0] rt, input int seed);
      int w0;
      fill(seed);
      w0 = wcount;
      drive(v);
      lhs_type = lt;
      rhs_type = rt;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check(err == 1'b1 && busy == 1'b0, "R4 reject flag", {err, busy}, 2);
      repeat (40) @(posedge clk);
      @(negedge clk);
      check(err == 1'b0 && busy == 1'b0 && done == 1'b0, "R4 stays idle", {err, busy, done}, 0);
      check(wcount == w0, "R4 no writes", wcount - w0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check({busy, done, err, wr_en, rd0_en, rd1_en} == 6'b0, "R6 reset state",
            {busy, done, err, wr_en, rd0_en, rd1_en}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int c = 0; c < NCASE; c++) run_case(VEC[c], c, 1'b0);
      run_case(VEC[2], 17, 1'b1);                 // R6 start and descriptor change ignored
      run_case(VEC[1], 23, 1'b0);                 // R2 8-bit again, fresh data
      reject_case(VEC[0], 2'd1, 2'd2, 31);        // R4 mismatch
      begin
         int vb[14];
         vb = VEC[1];
         vb[12] = 3;
         reject_case(vb, 2'd3, 2'd3, 37);         // R4 unused type code
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule